// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Block

This block collects status events from a motor-control or bus-transceiver front end and reports them through one interrupt request line. It watches two digital input pins, one bus receive line, three analog condition indicators (over-temperature, under-voltage and over-voltage) and a vector of power-stage fail latches that live outside the block. Software reaches an 8-bit flag register and an 8-bit enable register over a plain byte-wide register port.

The flags come from several kinds of source. The two pin flags record any edge. The bus wake flag records a release of the bus, but only after the bus has been held low for long enough. The three condition flags follow their conditions, and a clear is refused while the condition lasts. The fail summary bit mirrors the external latches. A third address passes a write-one-to-clear pulse through to those latches.

Every asynchronous input passes through two flops before any detection. The register port has no handshake: a write takes effect on the clock edge that samples `wr_en`, and `rdata` follows `addr` combinationally.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register and the enable register read 0x00 and `irq` is low.
- R2: The enable register at address 0x09 is read/write and keeps its value between writes. Reads at any address other than 0x09 and 0x0A return 0x00.
- R3: Flag bit 7 is set by either edge of `in_l`, but only while `run_mode` is 1. Flag bit 6 is set by either edge of `in_h`. A pin change is visible in the flag register three clock edges after it reaches the input.
- R4: At flag address 0x0A, writing 1 to a writable bit clears that bit, and writing 0 to it leaves it unchanged. Flag bit 4 always reads 0.
- R5: Flag bit 5 is set when `bus_rx` rises after it has been low for more than DOM_THR synchronized cycles. A shorter low period does not set it.
- R6: Flag bits 3, 2 and 1 (over-temperature, under-voltage, over-voltage) are set while their condition is active. A write-1 clear has no effect while the condition lasts. The flag stays set after the condition ends, until it is cleared.
- R7: When a set event and a write-1 clear of the same flag fall on the same clock edge, the flag stays set.
- R8: Flag bit 0 reads as the OR of `psf_latched` and is not changed by writes to 0x0A. A write to address 0x0B drives `psf_clr` with `wdata[NPSF-1:0]` during that write cycle. At all other times `psf_clr` is zero.
- R9: `irq` is the OR over bits 7, 6, 5, 3, 2, 1 and 0 of (flag AND enable). Enable bit 4 is a stored control bit that does not take part in `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_mode | input | 1 | Allows edges on `in_l` to set flag bit 7 |
| in_l | input | 1 | Asynchronous digital input, edge flag bit 7 |
| in_h | input | 1 | Asynchronous digital input, edge flag bit 6 |
| bus_rx | input | 1 | Asynchronous bus receive line, low is dominant |
| ovt | input | 1 | Asynchronous over-temperature indicator |
| uv | input | 1 | Asynchronous under-voltage indicator |
| ov | input | 1 | Asynchronous over-voltage indicator |
| psf_latched | input | NPSF | Outputs of the external power-stage fail latches |
| psf_clr | output | NPSF | Write-one-to-clear pulse to the fail latches |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The enable register is driven with random values over a fixed flag pattern, and the check that `irq` matches the bench's flag-AND-enable model shows whether each bit position is gated on its own and whether bit 4 is kept out. Directed toggles of `in_l` with `run_mode` low and then high show whether the run-mode gate works. Two low periods on `bus_rx`, one shorter and one longer than the threshold, show whether the dominant-time qualifier works. Clears issued while a condition is held, and on the same edge as a pin event, show whether a pending event can be lost.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h09;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 8'h0A;

  // flag / enable bit positions (software-visible layout)
  localparam int unsigned B_INL  = 7;
  localparam int unsigned B_INH  = 6;
  localparam int unsigned B_WAKE = 5;
  localparam int unsigned B_RSV  = 4;
  localparam int unsigned B_OT   = 3;
  localparam int unsigned B_UV   = 2;
  localparam int unsigned B_OV   = 1;
  localparam int unsigned B_PSF  = 0;

  // bits that hold a stored, clearable flag
  localparam logic [REG_W-1:0] STORED_BITS = 8'hEE;
  // bits that take part in the interrupt request
  localparam logic [REG_W-1:0] IRQ_BITS    = 8'hEF;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] any_edge
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign any_edge[i] = lvl[i] ^ prev[i];
  end
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
  parameter int unsigned DOM_THR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic hit
);
  localparam int unsigned CW = $clog2(DOM_THR + 2);
  localparam logic [CW-1:0] THR_C = CW'(DOM_THR);
  localparam logic [CW-1:0] SAT_C = CW'(DOM_THR + 1);

  logic [CW-1:0] low_cnt;
  logic          rx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      rx_prev <= 1'b0;
    end else begin
      rx_prev <= rx;
      if (rx)                  low_cnt <= '0;
      else if (low_cnt != SAT_C) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign hit = rx && !rx_prev && (low_cnt > THR_C);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned DOM_THR      = 16,
  parameter int unsigned NPSF         = 8,
  parameter logic [7:0]  PSF_CLR_ADDR = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_mode,
  input  logic              in_l,
  input  logic              in_h,
  input  logic              bus_rx,
  input  logic              ovt,
  input  logic              uv,
  input  logic              ov,
  input  logic [NPSF-1:0]   psf_latched,
  output logic [NPSF-1:0]   psf_clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  localparam int unsigned NSYNC = 6;

  logic [NSYNC-1:0] raw_in, syn;
  logic [1:0]       pin_edge;
  logic             wake_hit;
  logic             ot_s, uv_s, ov_s;
  logic [REG_W-1:0] set_vec, clr_vec, flag_q, flags_rd, mask_q;
  logic             psf_sum;

  assign raw_in = {in_l, in_h, bus_rx, ovt, uv, ov};

  irq_sync2 #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  irq_edge_det #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn[5:4]), .any_edge(pin_edge)
  );

  irq_wake_det #(.DOM_THR(DOM_THR)) u_wake (
    .clk(clk), .rst_n(rst_n), .rx(syn[3]), .hit(wake_hit)
  );

  assign ot_s = syn[2];
  assign uv_s = syn[1];
  assign ov_s = syn[0];

  always_comb begin
    set_vec         = '0;
    set_vec[B_INL]  = pin_edge[1] & run_mode;
    set_vec[B_INH]  = pin_edge[0];
    set_vec[B_WAKE] = wake_hit;
    set_vec[B_OT]   = ot_s;
    set_vec[B_UV]   = uv_s;
    set_vec[B_OV]   = ov_s;
  end

  assign clr_vec = (wr_en && addr == ADDR_FLAGS) ? wdata : '0;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (set_vec | (flag_q & ~clr_vec)) & STORED_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= '0;
    else if (wr_en && addr == ADDR_ENABLE) mask_q <= wdata;
  end

  assign psf_sum  = |psf_latched;
  assign flags_rd = flag_q | REG_W'(psf_sum);
  assign psf_clr  = (wr_en && addr == PSF_CLR_ADDR) ? wdata[NPSF-1:0] : '0;

  always_comb begin
    case (addr)
      ADDR_FLAGS:  rdata = flags_rd;
      ADDR_ENABLE: rdata = mask_q;
      default:     rdata = '0;
    endcase
  end

  assign irq = |(flags_rd & mask_q & IRQ_BITS);
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  flags,
  input logic [REG_W-1:0]  mask,
  input logic              irq,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic              ot_act,
  input logic              wake_hit
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask & IRQ_BITS) == '0) |-> !irq); // R9

  AST_OT_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    ot_act |=> flags[B_OT]); // R6

  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_FLAGS && !wdata[B_INL] && flags[B_INL]) |=> flags[B_INL]); // R4

  AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[B_WAKE]) |-> $past(wake_hit)); // R5

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_ENABLE) |=> $stable(mask)); // R2
endmodule

bind irq_flag_ctrl irq_flag_chk chk_i (
  .clk(clk), .rst_n(rst_n), .flags(flags_rd), .mask(mask_q), .irq(irq),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .ot_act(ot_s), .wake_hit(wake_hit)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  localparam int unsigned THR  = 16;
  localparam int unsigned NPSF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_mode = 1'b0, in_l = 1'b0, in_h = 1'b0, bus_rx = 1'b1;
  logic ovt = 1'b0, uv = 1'b0, ov = 1'b0;
  logic [NPSF-1:0] psf_latched = '0;
  logic [NPSF-1:0] psf_clr;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic wr_en = 1'b0, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_flag_ctrl #(.DOM_THR(THR), .NPSF(NPSF)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .in_l(in_l), .in_h(in_h),
    .bus_rx(bus_rx), .ovt(ovt), .uv(uv), .ov(ov), .psf_latched(psf_latched),
    .psf_clr(psf_clr), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  function automatic logic exp_irq(logic [7:0] f, logic [7:0] m);
    return |(f & m & 8'hEF);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    tick(4);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    rd(8'h0A, v); chk("R1 flags", v, 8'h00);
    rd(8'h09, v); chk("R1 enable", v, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // R2 enable register and unused address
    wr(8'h09, 8'hA5);
    rd(8'h09, v); chk("R2 enable readback", v, 8'hA5);
    rd(8'h33, v); chk("R2 unused addr", v, 8'h00);
    wr(8'h09, 8'h00);

    // R3 pin edges, run-mode gate
    run_mode = 1'b0; in_l = 1'b1; tick(3);
    rd(8'h0A, v); chk("R3 in_l gated", v, 8'h00);
    run_mode = 1'b1; in_l = 1'b0; tick(3);
    rd(8'h0A, v); chk("R3 in_l falling", v, 8'h80);
    in_h = 1'b1; tick(3);
    rd(8'h0A, v); chk("R3 in_h rising", v, 8'hC0);

    // R4 write-one-to-clear
    wr(8'h0A, 8'h00);
    rd(8'h0A, v); chk("R4 write zero", v, 8'hC0);
    wr(8'h0A, 8'h80);
    rd(8'h0A, v); chk("R4 clear bit7", v, 8'h40);
    wr(8'h0A, 8'h40);
    rd(8'h0A, v); chk("R4 clear bit6", v, 8'h00);

    // R7 set and clear on the same edge
    in_h = 1'b0; tick(3);
    rd(8'h0A, v); chk("R3 in_h falling", v, 8'h40);
    in_h = 1'b1; tick(2);
    wr(8'h0A, 8'h40);
    rd(8'h0A, v); chk("R7 set wins", v, 8'h40);
    wr(8'h0A, 8'h40);
    rd(8'h0A, v); chk("R4 clear after R7", v, 8'h00);

    // R5 bus wake qualifier
    bus_rx = 1'b0; tick(THR - 4); bus_rx = 1'b1; tick(3);
    rd(8'h0A, v); chk("R5 short dominant", v, 8'h00);
    bus_rx = 1'b0; tick(THR + 6); bus_rx = 1'b1; tick(3);
    rd(8'h0A, v); chk("R5 long dominant", v, 8'h20);
    wr(8'h0A, 8'h20);

    // R6 level conditions refuse clear while active
    ovt = 1'b1; tick(3);
    rd(8'h0A, v); chk("R6 ot set", v, 8'h08);
    wr(8'h0A, 8'h08);
    rd(8'h0A, v); chk("R6 ot clear refused", v, 8'h08);
    ovt = 1'b0; tick(3);
    rd(8'h0A, v); chk("R6 ot held", v, 8'h08);
    wr(8'h0A, 8'h08);
    rd(8'h0A, v); chk("R6 ot cleared", v, 8'h00);
    uv = 1'b1; ov = 1'b1; tick(3);
    wr(8'h0A, 8'h06);
    rd(8'h0A, v); chk("R6 uv ov refused", v, 8'h06);
    uv = 1'b0; ov = 1'b0; tick(3);
    wr(8'h0A, 8'h06);
    rd(8'h0A, v); chk("R6 uv ov cleared", v, 8'h00);

    // R8 fail summary and clear pulse
    psf_latched = 8'h10;
    rd(8'h0A, v); chk("R8 summary", v, 8'h01);
    wr(8'h0A, 8'h01);
    rd(8'h0A, v); chk("R8 read-only", v, 8'h01);
    addr = 8'h0B; wdata = 8'h10; wr_en = 1'b1;
    #1 chk("R8 clr pulse", psf_clr, 8'h10);
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R8 clr idle", psf_clr, 8'h00);
    psf_latched = 8'h00;
    rd(8'h0A, v); chk("R8 summary drop", v, 8'h00);

    // R9 interrupt gating: flags 0x82 (bit7 edge, bit1 held)
    in_l = 1'b1; ov = 1'b1; tick(3);
    rd(8'h0A, v); chk("R9 setup flags", v, 8'h82);
    wr(8'h09, 8'h10); #1 chk("R9 bit4 only", irq, 1'b0);
    wr(8'h09, 8'h7D); #1 chk("R9 other bits", irq, 1'b0);
    wr(8'h09, 8'h02); #1 chk("R9 ov enabled", irq, 1'b1);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] m;
      logic [7:0] f;
      m = 8'($urandom);
      f = 8'h82;
      if (i >= 20) begin
        psf_latched = 8'($urandom) & 8'h01;
        f = f | {7'b0, psf_latched[0]};
      end
      wr(8'h09, m);
      #1 chk("R9 random irq", irq, exp_irq(f, m));
      rd(8'h09, v); chk("R2 random enable", v, m);
    end
    finish_run();
  end
endmodule